// File: doc/BRIEF.md
# Quasi-Cyclic Message Memory Address Generator

This block drives the message-memory addressing of a partially parallel decoder for quasi-cyclic low-density parity-check codes. The parity-check matrix is a grid of square circulants of side `Z`. Each grid position either holds a cyclically shifted identity or is empty. Empty positions own no memory, so the memory block index counts only the occupied positions. A decode of one codeword runs `ITER` iterations. Each iteration is a check-node sweep followed by a variable-node sweep. Both sweeps walk the grid row by row and spend `Z` cycles on every occupied circulant.

During a check sweep, the address inside a circulant starts at that circulant's shift and wraps around modulo `Z`. During a variable sweep, the address simply counts from 0. A two-bit rate selector chooses one of three built-in grids, for rates 7/8, 3/4 and 1/2. The three grids have `NCOL/8`, `NCOL/4` and `NCOL/2` rows of `NCOL` columns. The selector is captured only when a codeword is launched, so consecutive codewords may use different rates. A stall input holds the walk in place.

The default parameters are `Z`=112, `NCOL`=72 (8064-bit codewords) and `ITER`=16. The shift tables are placeholders that a function computes.

Top module: `qc_addr_gen`

## Requirements
- R1: After reset, `busy`, `valid`, `phase_done` and `cw_done` are all 0.
- R2: A `start` while idle begins a codeword and captures `rate_sel`: 0 selects rate 7/8 with NCOL/8 rows, 1 selects 3/4 with NCOL/4 rows, and 2 or 3 select 1/2 with NCOL/2 rows. While `busy` is high, both `start` and `rate_sel` are ignored.
- R3: Grid position (r,c) under mode m is occupied iff (r + 2c + m) mod 3 ≠ 0, and its shift is (7r + 11c + 3m) mod Z. Positions are visited row-major. An occupied position takes Z unstalled cycles with `valid`=1. An empty position takes one unstalled cycle with `valid`=0. `blk` numbers the occupied positions from 0 within each sweep.
- R4: In a check sweep, the k-th address of a circulant (k = 0..Z-1) is (shift + k) mod Z.
- R5: In a variable sweep, the k-th address of a circulant is k.
- R6: `phase` is 0 in check sweeps and 1 in variable sweeps. A codeword runs ITER check/variable pairs, beginning with a check sweep.
- R7: `phase_done` is high on the last unstalled cycle of every sweep. `cw_done` is high only on the last cycle of the final variable sweep. `busy` falls on the following cycle.
- R8: While `stall` is high, `valid`, `phase_done` and `cw_done` are 0 and the walk position is held. The output stream resumes exactly where it stopped.
- R9: `addr` is always below Z while `valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a codeword when idle |
| rate_sel | input | 2 | Rate selector, captured at launch |
| stall | input | 1 | Hold the walk in place |
| busy | output | 1 | Codeword in progress |
| valid | output | 1 | Address outputs meaningful this cycle |
| phase | output | 1 | 0 check sweep, 1 variable sweep |
| blk | output | BW | Occupied-circulant memory index |
| addr | output | AW | Address inside the circulant |
| phase_done | output | 1 | Last cycle of a sweep |
| cw_done | output | 1 | Last cycle of the codeword |

## Verification
The bench targets circulants whose shift is nonzero, where the address must wrap from Z-1 to 0 partway through. A design that wraps too late, or that never wraps, shows up as an address of Z or more, or as a shifted sequence. Runs under mode 3 confirm that it aliases to the rate-1/2 grid, and every run changes `rate_sel` and pulses `start` mid-codeword. A block that resampled its inputs would jump to another grid or restart the walk. Stall patterns fall on empty positions, on circulant ends and on the final cycle of a sweep. A design that let a counter slip, or raised `phase_done` during a stall, would lose its alignment with the reference stream.

// File: rtl/qc_agen_pkg.sv
package qc_agen_pkg;
  typedef enum logic {PH_CHECK = 1'b0, PH_VAR = 1'b1} phase_e;

  // number of grid rows for a normalized mode (0, 1, 2)
  function automatic int rows_for(input logic [1:0] m, input int ncol);
    case (m)
      2'd0:    return ncol / 8;
      2'd1:    return ncol / 4;
      default: return ncol / 2;
    endcase
  endfunction

  // placeholder occupancy pattern of the grid
  function automatic logic circ_present(input logic [1:0] m, input int r, input int c);
    return ((r + 2 * c + int'(m)) % 3) != 0;
  endfunction

  // placeholder cyclic shift of an occupied position
  function automatic int circ_shift(input logic [1:0] m, input int r, input int c, input int z);
    return (7 * r + 11 * c + 3 * int'(m)) % z;
  endfunction

  // modular add of two operands already below z: one compare, one subtract
  function automatic int wrap_add(input int a, input int b, input int z);
    int s;
    s = a + b;
    if (s >= z) s = s - z;
    return s;
  endfunction
endpackage

// File: rtl/qc_circ_ctr.sv
module qc_circ_ctr
  import qc_agen_pkg::*;
#(
  parameter int Z  = 112,
  parameter int AW = $clog2(Z)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [AW-1:0] shift,
  input  phase_e        phase,
  output logic [AW-1:0] addr,
  output logic          k_last
);
  logic [AW-1:0] k_q;

  assign k_last = (int'(k_q) == Z - 1);
  assign addr   = (phase == PH_VAR) ? k_q : AW'(wrap_add(int'(shift), int'(k_q), Z));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   k_q <= '0;
    else if (clr) k_q <= '0;
    else if (adv) k_q <= k_last ? '0 : k_q + 1'b1;
  end

  // R4: inside one check circulant, each address is one more than the last, modulo Z
  a_r4_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !k_last && !clr && phase == PH_CHECK) |=>
      (int'(addr) == ((int'($past(addr)) == Z - 1) ? 0 : int'($past(addr)) + 1)));

  // R5: inside one variable circulant, the address increases by exactly one
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !k_last && !clr && phase == PH_VAR) |=> (int'(addr) == int'($past(addr)) + 1));

  // R9: address stays inside the circulant
  a_r9_addr_range: assert property (@(posedge clk) disable iff (!rst_n) int'(addr) < Z);
endmodule

// File: rtl/qc_grid_walk.sv
module qc_grid_walk #(
  parameter int NCOL = 72,
  parameter int RW   = 6,
  parameter int CW   = 7,
  parameter int BW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          present,
  input  logic [RW-1:0] row_last,
  output logic [RW-1:0] r,
  output logic [CW-1:0] c,
  output logic [BW-1:0] blk,
  output logic          at_end
);
  logic col_last;

  assign col_last = (int'(c) == NCOL - 1);
  assign at_end   = col_last && (r == row_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r <= '0; c <= '0; blk <= '0;
    end else if (clr) begin
      r <= '0; c <= '0; blk <= '0;
    end else if (step) begin
      if (present) blk <= blk + 1'b1;
      if (col_last) begin
        c <= '0;
        r <= r + 1'b1;
      end else begin
        c <= c + 1'b1;
      end
    end
  end

  // R3: leaving an occupied circulant advances the memory index by one
  a_r3_blk_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step && present && !clr) |=> (blk == $past(blk) + 1'b1));

  // R3: leaving an empty position allocates nothing
  a_r3_empty_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !present && !clr) |=> $stable(blk));
endmodule

// File: rtl/qc_addr_gen.sv
module qc_addr_gen
  import qc_agen_pkg::*;
#(
  parameter int Z    = 112,
  parameter int NCOL = 72,
  parameter int ITER = 16,
  localparam int AW  = $clog2(Z),
  localparam int BW  = $clog2(NCOL * (NCOL / 2) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    rate_sel,
  input  logic          stall,
  output logic          busy,
  output logic          valid,
  output logic          phase,
  output logic [BW-1:0] blk,
  output logic [AW-1:0] addr,
  output logic          phase_done,
  output logic          cw_done
);
  localparam int RW = (NCOL / 2 > 1) ? $clog2(NCOL / 2) : 1;
  localparam int CW = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int IW = $clog2(ITER + 1);

  logic          busy_q;
  logic [1:0]    mode_q;
  phase_e        phase_q;
  logic [IW-1:0] iter_q;

  logic [RW-1:0] r, row_last;
  logic [CW-1:0] c;
  logic [AW-1:0] shift_here;
  logic          tick, here_present, k_last, pos_end, step, grid_end;
  logic          sweep_end, last_iter, cw_end, launch, clr;

  assign tick         = busy_q && !stall;
  assign here_present = circ_present(mode_q, int'(r), int'(c));
  assign shift_here   = AW'(circ_shift(mode_q, int'(r), int'(c), Z));
  assign row_last     = RW'(rows_for(mode_q, NCOL) - 1);
  assign pos_end      = !here_present || k_last;
  assign step         = tick && pos_end;
  assign sweep_end    = step && grid_end;
  assign last_iter    = (int'(iter_q) == ITER - 1);
  assign cw_end       = sweep_end && (phase_q == PH_VAR) && last_iter;
  assign launch       = start && !busy_q;
  assign clr          = launch || sweep_end;

  qc_circ_ctr #(.Z(Z), .AW(AW)) u_circ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(tick && here_present),
    .shift(shift_here), .phase(phase_q), .addr(addr), .k_last(k_last)
  );

  qc_grid_walk #(.NCOL(NCOL), .RW(RW), .CW(CW), .BW(BW)) u_grid (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .present(here_present),
    .row_last(row_last), .r(r), .c(c), .blk(blk), .at_end(grid_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      mode_q  <= 2'd0;
      phase_q <= PH_CHECK;
      iter_q  <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      mode_q  <= (rate_sel == 2'd3) ? 2'd2 : rate_sel;
      phase_q <= PH_CHECK;
      iter_q  <= '0;
    end else if (sweep_end) begin
      if (phase_q == PH_CHECK) begin
        phase_q <= PH_VAR;
      end else begin
        phase_q <= PH_CHECK;
        if (last_iter) busy_q <= 1'b0;
        else           iter_q <= iter_q + 1'b1;
      end
    end
  end

  assign busy       = busy_q;
  assign valid      = tick && here_present;
  assign phase      = phase_q;
  assign phase_done = sweep_end;
  assign cw_done    = cw_end;

  // R2: the captured mode never changes during a codeword and is never 3
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (mode_q == $past(mode_q) && mode_q != 2'd3));

  // R7: the codeword end is also a sweep end, and busy drops right after it
  a_r7_done_order: assert property (@(posedge clk) disable iff (!rst_n)
    cw_done |-> phase_done);
  a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cw_done |=> !busy);

  // R8: a stalled cycle emits nothing and moves nothing
  a_r8_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!valid && !phase_done && !cw_done));
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stall) |=> ($stable(blk) && $stable(addr) && $stable(phase)));

  // R1: an idle block is silent
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!valid && !phase_done && !cw_done));
endmodule

// File: tb/qc_addr_gen_test.sv
module qc_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int TZ = 7;
  localparam int TN = 8;
  localparam int TI = 2;
  localparam int AW = $clog2(TZ);
  localparam int BW = $clog2(TN * (TN / 2) + 1);

  typedef struct {
    bit v; bit ph; int b; int a; bit pd; bit cd;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic stall = 1'b0;
  logic busy, valid, phase, phase_done, cw_done;
  logic [BW-1:0] blk;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  qc_addr_gen #(.Z(TZ), .NCOL(TN), .ITER(TI)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel), .stall(stall),
    .busy(busy), .valid(valid), .phase(phase), .blk(blk), .addr(addr),
    .phase_done(phase_done), .cw_done(cw_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference stream built from the requirement formulas
  task automatic build(input int m);
    int rows, b, last;
    rows = (m == 0) ? TN / 8 : (m == 1) ? TN / 4 : TN / 2;
    q.delete();
    for (int it = 0; it < TI; it++) begin
      for (int ph = 0; ph < 2; ph++) begin
        b = 0;
        for (int r = 0; r < rows; r++) begin
          for (int c = 0; c < TN; c++) begin
            if ((r + 2 * c + m) % 3 != 0) begin
              for (int k = 0; k < TZ; k++) begin
                exp_t e;
                e.v = 1; e.ph = ph[0]; e.b = b; e.pd = 0; e.cd = 0;
                e.a = (ph == 0) ? (((7 * r + 11 * c + 3 * m) % TZ) + k) % TZ : k;
                q.push_back(e);
              end
              b++;
            end else begin
              exp_t e;
              e.v = 0; e.ph = ph[0]; e.b = b; e.a = 0; e.pd = 0; e.cd = 0;
              q.push_back(e);
            end
          end
        end
        last = q.size() - 1;
        q[last].pd = 1;
        if (it == TI - 1 && ph == 1) q[last].cd = 1;
      end
    end
  endtask

  task automatic run(input logic [1:0] sel, input int stall_mod);
    int m, cnt;
    m = (sel == 2'd3) ? 2 : int'(sel);
    build(m);
    @(negedge clk);
    start = 1'b1; rate_sel = sel;
    @(negedge clk);
    start = 1'b0;
    rate_sel = sel + 2'd1;              // R2: change ignored while busy
    cnt = 0;
    while (q.size() > 0) begin
      stall = (stall_mod != 0) && (cnt % stall_mod == 3);
      start = (cnt == 5);               // R2: start while busy ignored
      #1;
      chk("R2", "busy", int'(busy), 1);
      if (stall) begin
        chk("R8", "valid in stall", int'(valid), 0);
        chk("R8", "phase_done in stall", int'(phase_done), 0);
        chk("R8", "cw_done in stall", int'(cw_done), 0);
        chk("R6", "phase in stall", int'(phase), int'(q[0].ph));
      end else begin
        chk("R3", "valid", int'(valid), int'(q[0].v));
        chk("R6", "phase", int'(phase), int'(q[0].ph));
        if (q[0].v) begin
          chk("R3", "blk", int'(blk), q[0].b);
          chk(q[0].ph ? "R5" : "R4", "addr", int'(addr), q[0].a);
          chk("R9", "addr range", int'(addr < AW'(TZ)), 1);
        end
        chk("R7", "phase_done", int'(phase_done), int'(q[0].pd));
        chk("R7", "cw_done", int'(cw_done), int'(q[0].cd));
        void'(q.pop_front());
      end
      cnt++;
      @(negedge clk);
    end
    start = 1'b0; stall = 1'b0;
    #1;
    chk("R7", "busy after codeword", int'(busy), 0);
    chk("R7", "valid after codeword", int'(valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy at reset", int'(busy), 0);
    chk("R1", "valid at reset", int'(valid), 0);
    chk("R1", "phase_done at reset", int'(phase_done), 0);
    chk("R1", "cw_done at reset", int'(cw_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "idle after release", int'(busy), 0);
    run(2'd0, 0);
    run(2'd1, 5);
    run(2'd2, 0);
    run(2'd3, 4);   // R2: mode 3 aliases to rate 1/2
    run(2'd2, 7);
    summary();
  end
endmodule